// File: doc/BRIEF.md
# Post-Update Indexed Store Unit

This unit carries out a store whose memory address is the current value of a base register, and then replaces that base register with the sum of base and index. One operation carries a size code, the number of the base register, and the values of the base, index and source registers. The unit turns it into a single write request on a 64-bit memory bus. The request carries the address, eight byte-lane enables and lane-aligned data, and moves under a valid/ready handshake. Once the memory side has taken the request, the unit issues one write on a register-file port that carries the updated base.

The unit is used next to an execution pipeline. The pipeline hands it an operation when `op_ready_o` is high and watches `done_o` to learn when both effects have completed. Two forms are refused: a base register number of zero, and an access whose bytes would spill past an 8-byte boundary. A refused operation writes neither memory nor a register and produces a one-cycle flag instead. The unit alters no status or special-purpose state.

Top module: `pu_store_unit`

## Requirements
- R1: An operation is accepted only on a rising edge with `op_valid_i` and `op_ready_o` both high. `op_ready_o` is high only when the unit is idle, and `op_valid_i` has no effect while the unit is busy.
- R2: The memory address of an accepted store is the unmodified base value (`op_base_val_i`), never base plus index.
- R3: Size codes 0, 1, 2 and 3 store 1, 2, 4 and 8 bytes. Lanes are numbered big-endian: an address offset o (the low three address bits) selects lane o. Lane o maps to `mem_be_o` bit 7-o, and enable bit j covers `mem_wdata_o[8j+7:8j]`. The enabled lanes are o through o+size-1.
- R4: The store data is the least-significant 8, 16, 32 or 64 bits of the source. Its most significant byte is placed on the lowest enabled lane, and every disabled lane carries zero.
- R5: `mem_req_valid_o` rises in the cycle after acceptance. Address, enables and data then stay stable until the cycle in which `mem_req_ready_i` is also high.
- R6: In the cycle after the memory handshake, `wb_valid_o` is high for exactly one cycle. In that cycle `wb_idx_o` is the base register number and `wb_data_o` is base plus index, modulo 2^64. No write-back happens before the handshake.
- R7: `done_o` is high for exactly one cycle, in the cycle after the write-back. The unit is idle again in the following cycle.
- R8: A base register number of zero raises `invalid_form_o` for one cycle, in the cycle after acceptance. Such an operation produces no memory request, no write-back and no `done_o`, and the unit stays ready.
- R9: An access with offset plus size greater than 8 raises `misaligned_o` for one cycle, in the cycle after acceptance, with no request, write-back or `done_o`. When the register number is also zero, only `invalid_form_o` is raised.
- R10: After reset, `op_ready_o` is high and every other output strobe or flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Unit idle and able to accept |
| op_size_i | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| op_base_idx_i | input | REG_IDX_W | Base register number |
| op_base_val_i | input | XLEN | Base register value |
| op_index_val_i | input | XLEN | Index register value |
| op_src_val_i | input | XLEN | Source register value |
| mem_req_valid_o | output | 1 | Memory write request valid |
| mem_req_ready_i | input | 1 | Memory side accepts request |
| mem_addr_o | output | XLEN | Write address |
| mem_be_o | output | XLEN/8 | Byte-lane enables |
| mem_wdata_o | output | XLEN | Lane-aligned write data |
| wb_valid_o | output | 1 | Register write-back strobe |
| wb_idx_o | output | REG_IDX_W | Register written back |
| wb_data_o | output | XLEN | Updated base value |
| invalid_form_o | output | 1 | Zero base register refused |
| misaligned_o | output | 1 | Boundary-crossing access refused |
| done_o | output | 1 | Store and write-back both finished |

## Verification
The bench builds the unit with its defaults, XLEN of 64 and a 5-bit register number. These give the eight-lane bus on which every lane offset can be combined with every size. That covers aligned stores at the first and last lanes, the largest offset that still fits for each size, and the first offset that crosses. An index of negative value exercises the wrap of the write-back sum. Holding the memory ready low for several cycles exposes the stability of the pending request and lets the bench offer operations, including refusable ones, while the unit is busy.

// File: rtl/pu_store_pkg.sv
package pu_store_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DBL = 2'd3} st_size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WB = 2'd2, ST_FIN = 2'd3} st_state_e;
endpackage

// File: rtl/pu_lane_steer.sv
module pu_lane_steer #(
  parameter int XLEN = 64
) (
  input  logic [1:0]                     size_i,
  input  logic [$clog2(XLEN/8)-1:0]      off_i,
  input  logic [XLEN-1:0]                src_i,
  output logic [XLEN/8-1:0]              be_o,
  output logic [XLEN-1:0]                data_o,
  output logic                           cross_o
);
  localparam int BYTES = XLEN / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int CNT_W = OFF_W + 5;

  logic [CNT_W-1:0] nbytes, start_pos, end_pos;
  logic [7:0]       src_b [BYTES];

  assign nbytes    = CNT_W'(1) << size_i;
  assign start_pos = CNT_W'(off_i);
  assign end_pos   = start_pos + nbytes;
  assign cross_o   = end_pos > CNT_W'(BYTES);

  for (genvar b = 0; b < BYTES; b++) begin : g_src
    assign src_b[b] = src_i[8*b +: 8];
  end

  // lane l is big-endian: lane 0 is the top byte of the bus
  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    localparam logic [CNT_W-1:0] LANE = CNT_W'(l);
    logic             hit;
    logic [CNT_W-1:0] k;
    assign hit = (LANE >= start_pos) && (LANE < end_pos);
    assign k   = end_pos - CNT_W'(1) - LANE;
    assign be_o[BYTES-1-l]          = hit;
    assign data_o[8*(BYTES-1-l) +: 8] = hit ? src_b[k[OFF_W-1:0]] : 8'h00;
  end
endmodule

// File: rtl/pu_ea_adder.sv
module pu_ea_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] index_i,
  output logic [XLEN-1:0] sum_o
);
  assign sum_o = base_i + index_i;
endmodule

// File: rtl/pu_store_ctrl.sv
module pu_store_ctrl
  import pu_store_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bad_form_i,
  input  logic cross_i,
  input  logic hs_i,
  output logic ready_o,
  output logic load_o,
  output logic req_valid_o,
  output logic wb_valid_o,
  output logic done_o,
  output logic invalid_o,
  output logic misaligned_o
);
  st_state_e state_q, state_d;
  logic accept;

  assign ready_o     = (state_q == ST_IDLE);
  assign accept      = start_i && ready_o;
  assign load_o      = accept && !bad_form_i && !cross_i;
  assign req_valid_o = (state_q == ST_REQ);
  assign wb_valid_o  = (state_q == ST_WB);
  assign done_o      = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_REQ;
      ST_REQ:  if (hs_i)   state_d = ST_WB;
      ST_WB:               state_d = ST_FIN;
      ST_FIN:              state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      invalid_o    <= 1'b0;
      misaligned_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      invalid_o    <= accept && bad_form_i;
      misaligned_o <= accept && !bad_form_i && cross_i; // zero register wins
    end
  end
endmodule

// File: rtl/pu_store_unit.sv
module pu_store_unit #(
  parameter int XLEN      = 64,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_valid_i,
  output logic                 op_ready_o,
  input  logic [1:0]           op_size_i,
  input  logic [REG_IDX_W-1:0] op_base_idx_i,
  input  logic [XLEN-1:0]      op_base_val_i,
  input  logic [XLEN-1:0]      op_index_val_i,
  input  logic [XLEN-1:0]      op_src_val_i,
  output logic                 mem_req_valid_o,
  input  logic                 mem_req_ready_i,
  output logic [XLEN-1:0]      mem_addr_o,
  output logic [XLEN/8-1:0]    mem_be_o,
  output logic [XLEN-1:0]      mem_wdata_o,
  output logic                 wb_valid_o,
  output logic [REG_IDX_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]      wb_data_o,
  output logic                 invalid_form_o,
  output logic                 misaligned_o,
  output logic                 done_o
);
  localparam int BYTES = XLEN / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [BYTES-1:0] be_c;
  logic [XLEN-1:0]  data_c, sum_c;
  logic             cross_c, bad_form_c, load, hs;

  assign bad_form_c = (op_base_idx_i == '0);
  assign hs         = mem_req_valid_o && mem_req_ready_i;

  pu_lane_steer #(.XLEN(XLEN)) u_steer (
    .size_i (op_size_i),
    .off_i  (op_base_val_i[OFF_W-1:0]),
    .src_i  (op_src_val_i),
    .be_o   (be_c),
    .data_o (data_c),
    .cross_o(cross_c)
  );

  pu_ea_adder #(.XLEN(XLEN)) u_adder (
    .base_i (op_base_val_i),
    .index_i(op_index_val_i),
    .sum_o  (sum_c)
  );

  pu_store_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (op_valid_i),
    .bad_form_i  (bad_form_c),
    .cross_i     (cross_c),
    .hs_i        (hs),
    .ready_o     (op_ready_o),
    .load_o      (load),
    .req_valid_o (mem_req_valid_o),
    .wb_valid_o  (wb_valid_o),
    .done_o      (done_o),
    .invalid_o   (invalid_form_o),
    .misaligned_o(misaligned_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      wb_idx_o    <= '0;
      wb_data_o   <= '0;
    end else if (load) begin
      mem_addr_o  <= op_base_val_i; // old base addresses memory
      mem_be_o    <= be_c;
      mem_wdata_o <= data_c;
      wb_idx_o    <= op_base_idx_i;
      wb_data_o   <= sum_c;
    end
  end
endmodule

// File: rtl/pu_store_unit_chk.sv
module pu_store_unit_chk #(
  parameter int XLEN      = 64,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 op_ready_o,
  input logic                 mem_req_valid_o,
  input logic                 mem_req_ready_i,
  input logic [XLEN-1:0]      mem_addr_o,
  input logic [XLEN/8-1:0]    mem_be_o,
  input logic [XLEN-1:0]      mem_wdata_o,
  input logic                 wb_valid_o,
  input logic [REG_IDX_W-1:0] wb_idx_o,
  input logic                 invalid_form_o,
  input logic                 misaligned_o,
  input logic                 done_o
);
  p_busy_not_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || wb_valid_o || done_o) |-> !op_ready_o);

  p_be_size_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> ($countones(mem_be_o) inside {1, 2, 4, 8}));

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_be_o) && $stable(mem_wdata_o)));

  p_wb_after_hs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(mem_req_valid_o && mem_req_ready_i));

  p_wb_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o);

  p_done_after_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wb_valid_o));

  p_no_zero_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_idx_o != '0));

  p_reject_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_form_o || misaligned_o) |-> (!mem_req_valid_o && !wb_valid_o && !done_o));

  p_flag_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({invalid_form_o, misaligned_o}));
endmodule

bind pu_store_unit pu_store_unit_chk #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .op_ready_o     (op_ready_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_addr_o     (mem_addr_o),
  .mem_be_o       (mem_be_o),
  .mem_wdata_o    (mem_wdata_o),
  .wb_valid_o     (wb_valid_o),
  .wb_idx_o       (wb_idx_o),
  .invalid_form_o (invalid_form_o),
  .misaligned_o   (misaligned_o),
  .done_o         (done_o)
);

// File: tb/pu_store_unit_test.sv
module pu_store_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic        op_ready_o;
  logic [1:0]  op_size_i = '0;
  logic [4:0]  op_base_idx_i = '0;
  logic [63:0] op_base_val_i = '0, op_index_val_i = '0, op_src_val_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [63:0] mem_addr_o, mem_wdata_o, wb_data_o;
  logic [7:0]  mem_be_o;
  logic        wb_valid_o;
  logic [4:0]  wb_idx_o;
  logic        invalid_form_o, misaligned_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pu_store_unit uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    chk_eq("R10 ready", 64'(op_ready_o), 64'd1);
    chk_eq("R10 strobes", 64'({mem_req_valid_o, wb_valid_o, done_o, invalid_form_o, misaligned_o}), 64'd0);
  endtask

  task automatic run_store(input string name, input logic [1:0] size, input logic [4:0] idx,
                           input logic [63:0] base, input logic [63:0] index,
                           input logic [63:0] src, input int wait_cyc, input bit poke);
    int n = 1 << size;
    int o = int'(base[2:0]);
    logic [63:0] mask = (n == 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
    logic [63:0] exp_data = (src & mask) << (8*(8-o-n));
    logic [7:0]  exp_be = 8'(((1 << n) - 1) << (8-o-n));
    @(negedge clk_i);
    op_size_i = size; op_base_idx_i = idx; op_base_val_i = base;
    op_index_val_i = index; op_src_val_i = src; op_valid_i = 1'b1;
    @(negedge clk_i);
    op_valid_i = poke;
    if (poke) begin op_base_idx_i = '0; op_base_val_i = 64'h7; op_size_i = 2'd3; end
    chk_eq({"R5 req valid ", name}, 64'(mem_req_valid_o), 64'd1);
    chk_eq({"R1 busy ", name}, 64'(op_ready_o), 64'd0);
    chk_eq({"R2 addr ", name}, mem_addr_o, base);
    chk_eq({"R3 be ", name}, 64'(mem_be_o), 64'(exp_be));
    chk_eq({"R4 data ", name}, mem_wdata_o, exp_data);
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk_i);
      chk((mem_req_valid_o === 1'b1) && (mem_addr_o === base) && (mem_wdata_o === exp_data)
          && (wb_valid_o === 1'b0), {"R5 hold ", name}, mem_addr_o, base);
    end
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    op_valid_i = 1'b0;
    chk_eq({"R6 wb valid ", name}, 64'({wb_valid_o, mem_req_valid_o}), 64'd2);
    chk_eq({"R6 wb idx ", name}, 64'(wb_idx_o), 64'(idx));
    chk_eq({"R6 wb data ", name}, wb_data_o, base + index);
    @(negedge clk_i);
    chk_eq({"R7 done ", name}, 64'({done_o, wb_valid_o}), 64'd2);
    @(negedge clk_i);
    chk_eq({"R7 idle ", name}, 64'({op_ready_o, done_o, mem_req_valid_o}), 64'd4);
    if (poke) chk_eq({"R1 ignored ", name}, 64'({invalid_form_o, misaligned_o}), 64'd0);
  endtask

  task automatic run_reject(input string name, input logic [1:0] size, input logic [4:0] idx,
                            input logic [63:0] base, input bit exp_inv, input bit exp_mis);
    @(negedge clk_i);
    op_size_i = size; op_base_idx_i = idx; op_base_val_i = base;
    op_index_val_i = 64'h100; op_src_val_i = 64'h1122_3344_5566_7788; op_valid_i = 1'b1;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk_eq({"R8 R9 flags ", name}, 64'({invalid_form_o, misaligned_o}), 64'({exp_inv, exp_mis}));
    chk_eq({"R8 no req ", name}, 64'({mem_req_valid_o, op_ready_o}), 64'd1);
    @(negedge clk_i);
    chk_eq({"R9 quiet ", name},
           64'({invalid_form_o, misaligned_o, mem_req_valid_o, wb_valid_o, done_o}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    run_store("byte off0", 2'd0, 5'd3, 64'h1000, 64'h8, 64'hDEAD_BEEF_CAFE_F00D, 0, 1'b0);
    run_store("byte off5", 2'd0, 5'd4, 64'h2005, 64'h1, 64'h0123_4567_89AB_CDEF, 2, 1'b0);
    run_store("byte off7", 2'd0, 5'd31, 64'h3007, 64'h10, 64'hFFFF_FFFF_FFFF_FF5A, 1, 1'b0);
    run_store("half off0", 2'd1, 5'd5, 64'h4000, 64'h2, 64'h0000_0000_0000_ABCD, 0, 1'b0);
    run_store("half off6", 2'd1, 5'd6, 64'h4006, 64'h20, 64'h1111_2222_3333_4455, 3, 1'b1);
    run_store("word off4", 2'd2, 5'd7, 64'h5004, 64'hFFFF_FFFF_FFFF_FFFC, 64'hAAAA_BBBB_1234_5678, 1, 1'b0);
    run_store("word off2", 2'd2, 5'd8, 64'h5002, 64'h40, 64'h9999_8888_7766_5544, 0, 1'b0);
    run_store("dbl off0", 2'd3, 5'd9, 64'h6008, 64'h8, 64'h0102_0304_0506_0708, 4, 1'b1);
    run_store("dbl wrap", 2'd3, 5'd1, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 64'hFEDC_BA98_7654_3210, 0, 1'b0);
    run_reject("zero reg", 2'd0, 5'd0, 64'h7000, 1'b1, 1'b0);
    run_reject("half off7", 2'd1, 5'd2, 64'h7007, 1'b0, 1'b1);
    run_reject("word off5", 2'd2, 5'd2, 64'h7005, 1'b0, 1'b1);
    run_reject("dbl off3", 2'd3, 5'd2, 64'h7003, 1'b0, 1'b1);
    run_reject("zero and cross", 2'd3, 5'd0, 64'h7001, 1'b1, 1'b0);
    run_store("after reject", 2'd2, 5'd10, 64'h8000, 64'h4, 64'h0000_0000_CAFE_BABE, 1, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule